// File: doc/BRIEF.md
# Modem Line Status Change Register

This block is a host-readable status register for a serial port's modem-control side. It watches four modem handshake lines: carrier detect, ring indicator, data-set-ready and clear-to-send. It shows their present levels in the upper half of an 8-bit register. In the lower half it keeps sticky flags that record which lines changed since the host last read the register. A read clears the flags. While any flag is set, the block raises an interrupt request.

For self-test, a loopback mode swaps the external lines for four outputs of the port's control register. Each status level then follows a fixed control bit. A change caused by entering or leaving loopback counts as an ordinary line change. External lines pass through a synchroniser before any edge is detected.

The host reads through a one-cycle strobe and an address. Only a strobe at offset 6 returns this register and clears its flags.

Top module: `mdm_stat_reg`

## Requirements
- R1: `line_in` bit 3 is carrier, bit 2 is ring, bit 1 is data-set-ready and bit 0 is clear-to-send. Register bits 7, 6, 5 and 4 show the current effective level of carrier, ring, data-set-ready and clear-to-send respectively.
- R2: Register bits 3 (carrier), 1 (data-set-ready) and 0 (clear-to-send) go to 1 when their line changes in either direction. Once set, they stay set until cleared.
- R3: Register bit 2 goes to 1 only when the ring level falls from 1 to 0. A rising ring level leaves it unchanged.
- R4: A read strobe with `rd_addr` equal to 6 clears bits 3..0 from the next cycle on. Reset also clears them, and it clears `rd_data` as well.
- R5: A read strobe at any other address leaves the flags and `rd_data` unchanged.
- R6: If a line change is detected in the same cycle as a clearing read, that read returns the flags without the new change. The new flag is set after the clear and is not lost.
- R7: `irq_out` is 1 exactly when at least one of bits 3..0 is 1.
- R8: When `ctl_bits[4]` is 1 (loopback), the effective levels come from the control bits and `line_in` is ignored. Carrier takes `ctl_bits[3]`, ring takes `ctl_bits[2]`, data-set-ready takes `ctl_bits[0]` and clear-to-send takes `ctl_bits[1]`.
- R9: Entering or leaving loopback sets change flags for every effective level that differs, under the rules of R2 and R3.
- R10: A change on `line_in` reaches the register and `irq_out` on the third rising clock edge after it. In loopback, a control bit change reaches them on the first edge.
- R11: `rd_data` is loaded, on the edge that samples a clearing read, with the register value that was current in that read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 4 | Asynchronous modem lines {carrier, ring, dsr, cts} |
| ctl_bits | input | 5 | Control register: [4] loopback, [3] out2, [2] out1, [1] rts, [0] dtr |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Register value captured by the last read at offset 6 |
| irq_out | output | 1 | Modem status interrupt request |

## Verification
On every cycle, the embedded assertions check the following:
- any-edge flags are set, and ring flags are set only on falling edges;
- flags stay set until a read;
- a quiet read clears the flags;
- read data matches the register value from the read cycle;
- misaddressed reads leave the read data alone.

Only the bench scenarios can show the remaining behaviour:
- bit ordering on the external pins;
- the loopback routing of each control bit;
- the flags raised by toggling loopback;
- the three-edge synchroniser latency;
- a change that coincides with a read is kept for the next read.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;
   localparam int unsigned LINE_W = 4;
   localparam int unsigned CTL_W  = 5;
   localparam int unsigned REG_W  = 8;

   // positions within the four-line vector
   localparam int unsigned L_CTS = 0;
   localparam int unsigned L_DSR = 1;
   localparam int unsigned L_RNG = 2;
   localparam int unsigned L_CAR = 3;

   // positions within the control vector
   localparam int unsigned C_DTR  = 0;
   localparam int unsigned C_RTS  = 1;
   localparam int unsigned C_OUT1 = 2;
   localparam int unsigned C_OUT2 = 3;
   localparam int unsigned C_LOOP = 4;

   // flags that react to either edge; the ring flag reacts to falls only
   localparam logic [LINE_W-1:0] ANY_EDGE_MASK = 4'b1011;

   typedef logic [LINE_W-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= async_in;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/mdm_lvl_sel.sv
module mdm_lvl_sel
   import mdm_stat_pkg::*;
#(
   parameter bit LOOPBACK_EN = 1'b1
) (
   input  line_vec_t         pin_lvl,
   input  logic [CTL_W-1:0]  ctl_bits,
   output line_vec_t         eff_lvl
);
   if (LOOPBACK_EN) begin : g_loop
      line_vec_t loop_lvl;
      always_comb begin
         loop_lvl        = '0;
         loop_lvl[L_CAR] = ctl_bits[C_OUT2];
         loop_lvl[L_RNG] = ctl_bits[C_OUT1];
         loop_lvl[L_DSR] = ctl_bits[C_DTR];
         loop_lvl[L_CTS] = ctl_bits[C_RTS];
      end
      assign eff_lvl = ctl_bits[C_LOOP] ? loop_lvl : pin_lvl;
   end else begin : g_pins
      assign eff_lvl = pin_lvl;
   end
endmodule

// File: rtl/mdm_delta_flags.sv
module mdm_delta_flags
   import mdm_stat_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  line_vec_t lvl_in,
   input  logic      clr,
   output line_vec_t lvl_q,
   output line_vec_t flags
);
   line_vec_t diff;
   line_vec_t set_vec;

   always_comb begin
      diff           = lvl_in ^ lvl_q;
      set_vec        = diff & ANY_EDGE_MASK;
      set_vec[L_RNG] = lvl_q[L_RNG] & ~lvl_in[L_RNG];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         flags <= '0;
      end else begin
         lvl_q <= lvl_in;
         flags <= (clr ? '0 : flags) | set_vec;
      end
   end

   // R2
   any_edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl_in ^ lvl_q) & ANY_EDGE_MASK) != '0 |=>
      (flags & $past((lvl_in ^ lvl_q) & ANY_EDGE_MASK)) == $past((lvl_in ^ lvl_q) & ANY_EDGE_MASK));

   // R3
   ring_fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[L_RNG] && !lvl_in[L_RNG]) |=> flags[L_RNG]);

   // R3
   ring_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_q[L_RNG] && lvl_in[L_RNG] && (clr || !flags[L_RNG])) |=> !flags[L_RNG]);

   // R4
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && lvl_in == lvl_q) |=> flags == '0);

   // R2
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (flags & $past(flags)) == $past(flags));
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
   import mdm_stat_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned REG_OFFSET  = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LOOPBACK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_in,
   input  logic [CTL_W-1:0]  ctl_bits,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq_out
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mdm_stat_reg: SYNC_STAGES must be at least 2");
   end
   if (REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
      $error("mdm_stat_reg: REG_OFFSET does not fit in ADDR_W bits");
   end

   line_vec_t pin_lvl, eff_lvl, lvl_q, flags;
   logic      hit;

   mdm_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (line_in),
      .sync_out (pin_lvl)
   );

   mdm_lvl_sel #(.LOOPBACK_EN(LOOPBACK_EN)) u_sel (
      .pin_lvl  (pin_lvl),
      .ctl_bits (ctl_bits),
      .eff_lvl  (eff_lvl)
   );

   assign hit = rd_stb && (rd_addr == HIT_ADDR);

   mdm_delta_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_in (eff_lvl),
      .clr    (hit),
      .lvl_q  (lvl_q),
      .flags  (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_data <= '0;
      else if (hit) rd_data <= {lvl_q, flags};
   end

   assign irq_out = |flags;

   // R11
   read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> rd_data == $past({lvl_q, flags}));

   // R5
   miss_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(rd_data));
endmodule

// File: tb/mdm_stat_reg_bench.sv
module mdm_stat_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] line_in = '0;
   logic [4:0] ctl_bits = '0;
   logic       rd_stb = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   mdm_stat_reg u_mdm_stat_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (line_in),
      .ctl_bits (ctl_bits),
      .rd_stb   (rd_stb),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .irq_out  (irq_out)
   );

   // {line_in, ctl_bits, expected read byte, expected irq before read}
   localparam logic [17:0] VEC [11] = '{
      {4'b0001, 5'b00000, 8'h11, 1'b1},  // R1 R2 cts rises
      {4'b0101, 5'b00000, 8'h50, 1'b0},  // R3 ring rises: no flag
      {4'b0001, 5'b00000, 8'h14, 1'b1},  // R3 ring falls
      {4'b1011, 5'b00000, 8'hBA, 1'b1},  // R2 carrier and dsr rise
      {4'b0000, 5'b00000, 8'h0B, 1'b1},  // R2 falls
      {4'b1111, 5'b10000, 8'h00, 1'b0},  // R8 loopback hides pins
      {4'b1111, 5'b11000, 8'h88, 1'b1},  // R8 out2 -> carrier
      {4'b1111, 5'b10100, 8'h48, 1'b1},  // R8 out1 -> ring
      {4'b1111, 5'b10001, 8'h26, 1'b1},  // R8 dtr -> dsr
      {4'b1111, 5'b10010, 8'h13, 1'b1},  // R8 rts -> cts
      {4'b1111, 5'b00010, 8'hFA, 1'b1}   // R9 leaving loopback
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] ln, input logic [4:0] cb);
      @(negedge clk);
      line_in  = ln;
      ctl_bits = cb;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_read(input logic [2:0] addr);
      rd_stb  = 1'b1;
      rd_addr = addr;
      @(negedge clk);
      rd_stb  = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R4 reset state
      check("R4 reset rd_data", rd_data, 8'h00);
      check("R7 reset irq", {7'd0, irq_out}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 11; i++) begin
         apply(VEC[i][17:14], VEC[i][13:9]);
         check($sformatf("R7 vec%0d irq", i), {7'd0, irq_out}, {7'd0, VEC[i][0]});
         do_read(3'd6);
         check($sformatf("R11 vec%0d read", i), rd_data, VEC[i][8:1]);
      end
      // R4 flags cleared after read
      check("R4 irq after read", {7'd0, irq_out}, 8'h00);

      // R5 misaddressed read
      apply(4'b1110, 5'b00010);
      check("R2 irq cts fall", {7'd0, irq_out}, 8'h01);
      do_read(3'd5);
      check("R5 rd_data held", rd_data, 8'hFA);
      check("R5 irq still set", {7'd0, irq_out}, 8'h01);
      do_read(3'd6);
      check("R5 flag survived", rd_data, 8'hE1);

      // R9 entering loopback with all control outputs low
      apply(4'b1110, 5'b10000);
      do_read(3'd6);
      check("R9 enter loopback", rd_data, 8'h0E);

      // R6 change in the same cycle as a read; R10 loopback one edge
      ctl_bits = 5'b10010;
      rd_stb   = 1'b1;
      rd_addr  = 3'd6;
      @(negedge clk);
      rd_stb   = 1'b0;
      check("R6 read returns old", rd_data, 8'h00);
      check("R6 R10 new flag kept", {7'd0, irq_out}, 8'h01);
      do_read(3'd6);
      check("R6 later read", rd_data, 8'h11);

      // R8 pins ignored in loopback
      apply(4'b0000, 5'b10010);
      check("R8 pin change ignored irq", {7'd0, irq_out}, 8'h00);
      do_read(3'd6);
      check("R8 pin change ignored data", rd_data, 8'h10);

      // R9 leaving loopback, cts falls
      apply(4'b0000, 5'b00000);
      do_read(3'd6);
      check("R9 leave loopback", rd_data, 8'h01);

      // R10 synchroniser latency
      line_in = 4'b0001;
      @(negedge clk);
      @(negedge clk);
      check("R10 not before third edge", {7'd0, irq_out}, 8'h00);
      @(negedge clk);
      check("R10 at third edge", {7'd0, irq_out}, 8'h01);
      do_read(3'd6);
      check("R1 cts level", rd_data, 8'h11);

      finish_run();
   end
endmodule